// File: doc/BRIEF.md
# RTC Timekeeping Update Sequencer

This block holds the time-of-day and calendar registers of a real-time clock (seconds, minutes, hours, day of week, day of month, month, two-digit year) and advances them by one second each time a once-per-second tick arrives. Each tick starts a timed update window. A busy flag, visible to the host in control register A, goes high at the start of the window. The new time is committed at the closing edge of the window, in the same cycle that the flag drops. While the flag is low, the host can rely on every time register holding a settled value.

The host reaches the registers by index over a byte-wide interface. Writes are synchronous and reads are combinational. Control register B selects the data format (packed BCD or plain binary) and the hour format (24-hour, or 12-hour with a PM marker in bit 7). It also holds a freeze bit that stops updates while the host loads a new time. The window length is set by two parameters, a lead part and an update part, both counted in clock cycles.

Top module: `rtc_time_sequencer`

## Requirements
- R1: After reset the time reads 00:00:00, day of week 1, date 1, month 1, year 0. Register A (index 10) reads 0x00 and register B (index 11) reads 0x02, which selects 24-hour BCD with the freeze bit clear.
- R2: The time registers sit at these indices: seconds 0, minutes 2, hours 4, day of week 6, day of month 7, month 8, year 9. Writes to them read back unchanged. Indices 1, 3, 5, 14 and 15 read 0x00 and ignore writes.
- R3: A tick sampled while idle with the freeze bit clear raises bit 7 of register A at that edge. The bit stays high for exactly LEAD_CYC+UPD_CYC cycles and clears at the edge where the time registers take their new values.
- R4: A tick that arrives while the update window is open is ignored. It neither lengthens the window nor starts a second one.
- R5: Time registers change only at the end of an update window or on a host write. During the window they still read the old time.
- R6: While bit 7 of register B (freeze) is set, ticks start no update. Setting freeze during an open window closes the window without changing the time.
- R7: With register B bit 2 clear, every time field is packed BCD (tens digit in bits 7:4, units in bits 3:0). A units-digit carry takes 0x09 to 0x10, and 0x59 seconds wraps to 0x00 with a minute carry.
- R8: With register B bit 2 set, every field is plain binary, so 59 seconds (0x3B) wraps to 0x00 with a minute carry.
- R9: With register B bit 1 set (24-hour), hours count 0 to 23, and 23 wraps to 0 with a day carry.
- R10: With register B bit 1 clear (12-hour), hours count 12, 1, ..., 11 in bits 6:0, with bit 7 meaning PM. Going from 11 to 12 toggles bit 7, and 11 PM to 12 AM carries into the day.
- R11: Day of month wraps to 1 after the last day of the current month. February has 29 days when the two-digit year is divisible by 4 and 28 days otherwise. Month 12 wraps to 1 with a year carry, and year 99 wraps to 0.
- R12: Day of week counts 1 to 7 and advances on every day carry, and 7 wraps to 1.
- R13: Register D (index 13) always reads 0x80 and ignores writes. Register C (index 12) reads 0x00. Bit 7 of register A is read-only, and bits 6:0 of register A store what the host writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| reg_addr | input | 4 | Register index for read and write |
| reg_we | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data of the indexed register |

## Verification
The hardest situation to reach is a single tick that ripples a carry through every field at once, from seconds into the year, in each of the four format combinations. Random starting times alone almost never land on those boundaries. The stimulus therefore biases random seconds and minutes toward 59 and often places the date on the last day of its month. Directed loads then cover New Year of year 99, the February boundaries in leap and common years, and the three 12-hour crossings. Freeze is raised partway through an open window, and a second tick is injected during a window, to show that no time change leaks through.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;

    localparam logic [3:0] IDX_SEC = 4'd0;
    localparam logic [3:0] IDX_MIN = 4'd2;
    localparam logic [3:0] IDX_HR  = 4'd4;
    localparam logic [3:0] IDX_DOW = 4'd6;
    localparam logic [3:0] IDX_DOM = 4'd7;
    localparam logic [3:0] IDX_MON = 4'd8;
    localparam logic [3:0] IDX_YR  = 4'd9;
    localparam logic [3:0] IDX_CA  = 4'd10;
    localparam logic [3:0] IDX_CB  = 4'd11;
    localparam logic [3:0] IDX_CC  = 4'd12;
    localparam logic [3:0] IDX_CD  = 4'd13;

    localparam int unsigned CB_FREEZE = 7;
    localparam int unsigned CB_BINARY = 2;
    localparam int unsigned CB_H24    = 1;

    localparam logic [7:0] CB_RESET   = 8'h02;
    localparam logic [7:0] CD_VALUE   = 8'h80;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hr;
        logic [7:0] dow;
        logic [7:0] dom;
        logic [7:0] mon;
        logic [7:0] yr;
    } rtc_time_t;

    typedef struct packed {
        logic binary;
        logic h24;
    } rtc_fmt_t;

    localparam rtc_time_t TIME_RESET = '{sec: 8'h00, min: 8'h00, hr: 8'h00,
                                         dow: 8'h01, dom: 8'h01, mon: 8'h01,
                                         yr: 8'h00};

    // Stored field -> binary value 0..99
    function automatic logic [6:0] fmt_to_bin(input logic [7:0] v, input logic binary);
        logic [6:0] r;
        if (binary) r = v[6:0];
        else        r = {3'b000, v[7:4]} * 7'd10 + {3'b000, v[3:0]};
        return r;
    endfunction

    // Binary value 0..99 -> stored field
    function automatic logic [7:0] bin_to_fmt(input logic [6:0] n, input logic binary);
        logic [6:0] tens;
        logic [6:0] units;
        tens  = n / 7'd10;
        units = n % 7'd10;
        if (binary) return {1'b0, n};
        return {tens[3:0], units[3:0]};
    endfunction

    // Stored hour field -> 0..23
    function automatic logic [6:0] hr_to_24(input logic [7:0] v, input logic binary,
                                            input logic h24);
        logic [6:0] h;
        if (h24) return fmt_to_bin(v, binary);
        h = fmt_to_bin({1'b0, v[6:0]}, binary);
        if (h == 7'd12) h = 7'd0;
        return h + (v[7] ? 7'd12 : 7'd0);
    endfunction

    // 0..23 -> stored hour field
    function automatic logic [7:0] hr_from_24(input logic [6:0] h, input logic binary,
                                              input logic h24);
        logic [6:0] hh;
        logic [7:0] enc;
        if (h24) return bin_to_fmt(h, binary);
        hh = (h >= 7'd12) ? h - 7'd12 : h;
        if (hh == 7'd0) hh = 7'd12;
        enc = bin_to_fmt(hh, binary);
        return {(h >= 7'd12), enc[6:0]};
    endfunction

    function automatic logic [6:0] month_len(input logic [6:0] mon, input logic [6:0] yr);
        case (mon)
            7'd2:                    return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
            default:                 return 7'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_seq_timer.sv
module rtc_seq_timer
    import rtc_seq_pkg::*;
#(
    parameter int unsigned LEAD_CYC = 3,
    parameter int unsigned UPD_CYC  = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic freeze,
    output logic busy,
    output logic commit
);
    localparam int unsigned WIN = LEAD_CYC + UPD_CYC;
    localparam int unsigned CW  = $clog2(WIN + 1);
    localparam logic [CW-1:0] LAST = CW'(WIN - 1);

    logic [CW-1:0] cnt;

    assign commit = busy && (cnt == LAST) && !freeze;

    always_ff @(posedge clk) begin
        if (rst || freeze) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == LAST) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end else if (tick) begin
            busy <= 1'b1;
            cnt  <= '0;
        end
    end

    AST_RISE_FROM_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(tick)); // R3
    AST_COMMIT_CLOSES: assert property (@(posedge clk) disable iff (rst)
        commit |=> (!busy && cnt == '0)); // R3
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
        (busy && !commit && !freeze) |=> (busy && cnt == $past(cnt) + CW'(1))); // R4
    AST_FREEZE_IDLE: assert property (@(posedge clk) disable iff (rst)
        freeze |=> !busy); // R6

endmodule

// File: rtl/rtc_seq_calendar.sv
module rtc_seq_calendar
    import rtc_seq_pkg::*;
(
    input  rtc_time_t cur,
    input  rtc_fmt_t  fmt,
    output rtc_time_t nxt
);
    logic [6:0] s, m, h, w, d, mo, y;
    logic [6:0] ns, nm, nh, nw, nd, nmo, ny;
    logic       c_min, c_hr, c_day, c_mon, c_yr;

    always_comb begin
        s  = fmt_to_bin(cur.sec, fmt.binary);
        m  = fmt_to_bin(cur.min, fmt.binary);
        h  = hr_to_24(cur.hr, fmt.binary, fmt.h24);
        w  = fmt_to_bin(cur.dow, fmt.binary);
        d  = fmt_to_bin(cur.dom, fmt.binary);
        mo = fmt_to_bin(cur.mon, fmt.binary);
        y  = fmt_to_bin(cur.yr, fmt.binary);

        c_min = (s >= 7'd59);
        c_hr  = c_min && (m >= 7'd59);
        c_day = c_hr && (h >= 7'd23);
        c_mon = c_day && (d >= month_len(mo, y));
        c_yr  = c_mon && (mo >= 7'd12);

        ns  = c_min ? 7'd0 : s + 7'd1;
        nm  = c_min ? (c_hr ? 7'd0 : m + 7'd1) : m;
        nh  = c_hr ? (c_day ? 7'd0 : h + 7'd1) : h;
        nw  = c_day ? ((w >= 7'd7) ? 7'd1 : w + 7'd1) : w;
        nd  = c_day ? (c_mon ? 7'd1 : d + 7'd1) : d;
        nmo = c_mon ? (c_yr ? 7'd1 : mo + 7'd1) : mo;
        ny  = c_yr ? ((y >= 7'd99) ? 7'd0 : y + 7'd1) : y;

        nxt.sec = bin_to_fmt(ns, fmt.binary);
        nxt.min = bin_to_fmt(nm, fmt.binary);
        nxt.hr  = hr_from_24(nh, fmt.binary, fmt.h24);
        nxt.dow = bin_to_fmt(nw, fmt.binary);
        nxt.dom = bin_to_fmt(nd, fmt.binary);
        nxt.mon = bin_to_fmt(nmo, fmt.binary);
        nxt.yr  = bin_to_fmt(ny, fmt.binary);
    end

endmodule

// File: rtl/rtc_time_sequencer.sv
module rtc_time_sequencer
    import rtc_seq_pkg::*;
#(
    parameter int unsigned LEAD_CYC = 3,
    parameter int unsigned UPD_CYC  = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_tick,
    input  logic [3:0] reg_addr,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata
);
    rtc_time_t  tm;
    rtc_time_t  tm_next;
    rtc_fmt_t   fmt;
    logic [6:0] ctl_a;
    logic [7:0] ctl_b;
    logic       uip;
    logic       commit;
    logic       past_ok;

    assign fmt = '{binary: ctl_b[CB_BINARY], h24: ctl_b[CB_H24]};

    rtc_seq_timer #(
        .LEAD_CYC (LEAD_CYC),
        .UPD_CYC  (UPD_CYC)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick   (sec_tick),
        .freeze (ctl_b[CB_FREEZE]),
        .busy   (uip),
        .commit (commit)
    );

    rtc_seq_calendar u_cal (
        .cur (tm),
        .fmt (fmt),
        .nxt (tm_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tm    <= TIME_RESET;
            ctl_a <= '0;
            ctl_b <= CB_RESET;
        end else begin
            if (commit) tm <= tm_next;
            if (reg_we) begin
                case (reg_addr)
                    IDX_SEC: tm.sec <= reg_wdata;
                    IDX_MIN: tm.min <= reg_wdata;
                    IDX_HR:  tm.hr  <= reg_wdata;
                    IDX_DOW: tm.dow <= reg_wdata;
                    IDX_DOM: tm.dom <= reg_wdata;
                    IDX_MON: tm.mon <= reg_wdata;
                    IDX_YR:  tm.yr  <= reg_wdata;
                    IDX_CA:  ctl_a  <= reg_wdata[6:0];
                    IDX_CB:  ctl_b  <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (reg_addr)
            IDX_SEC: reg_rdata = tm.sec;
            IDX_MIN: reg_rdata = tm.min;
            IDX_HR:  reg_rdata = tm.hr;
            IDX_DOW: reg_rdata = tm.dow;
            IDX_DOM: reg_rdata = tm.dom;
            IDX_MON: reg_rdata = tm.mon;
            IDX_YR:  reg_rdata = tm.yr;
            IDX_CA:  reg_rdata = {uip, ctl_a};
            IDX_CB:  reg_rdata = ctl_b;
            IDX_CC:  reg_rdata = 8'h00;
            IDX_CD:  reg_rdata = CD_VALUE;
            default: reg_rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_STABLE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !uip && !$past(uip) && !$past(reg_we)) |-> $stable(tm)); // R5
    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(ctl_b[CB_FREEZE]) && !$past(reg_we)) |-> $stable(tm)); // R6

endmodule

// File: tb/rtc_time_sequencer_bench.sv
`timescale 1ns/10ps
module rtc_time_sequencer_bench;

    localparam int LEAD = 3;
    localparam int UPD  = 5;
    localparam int WIN  = LEAD + UPD;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic [3:0] reg_addr = 4'd0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;

    int total = 0;
    int fails = 0;

    // expected time, decoded
    int es, em, eh, ew, ed, emo, ey;
    bit mbin, mh24;

    rtc_time_sequencer #(.LEAD_CYC(LEAD), .UPD_CYC(UPD)) u_rtc_time_sequencer (
        .clk       (clk),
        .rst       (rst),
        .sec_tick  (sec_tick),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    always #2 clk = ~clk;

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: run did not finish, act=hung exp=done");
        summary();
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    function automatic logic [7:0] enc(input int v, input bit bin);
        if (bin) return 8'(v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] enc_hr(input int h, input bit bin, input bit h24);
        int h12;
        logic [7:0] r;
        if (h24) return enc(h, bin);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        r = enc(h12, bin);
        if (h >= 12) r[7] = 1'b1;
        return r;
    endfunction

    function automatic int dim(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] cb_val(input bit frz, input bit bin, input bit h24);
        return {frz, 4'b0000, bin, h24, 1'b0};
    endfunction

    task automatic model_step();
        es++;
        if (es == 60) begin
            es = 0; em++;
            if (em == 60) begin
                em = 0; eh++;
                if (eh == 24) begin
                    eh = 0;
                    ew = (ew == 7) ? 1 : ew + 1;
                    ed++;
                    if (ed > dim(emo, ey)) begin
                        ed = 1; emo++;
                        if (emo == 13) begin
                            emo = 1;
                            ey = (ey + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    task automatic set_model(input int s, input int m, input int h, input int w,
                             input int d, input int mo, input int y,
                             input bit bin, input bit h24);
        es = s; em = m; eh = h; ew = w; ed = d; emo = mo; ey = y;
        mbin = bin; mh24 = h24;
    endtask

    task automatic load_time();
        wr(4'd11, cb_val(1'b1, mbin, mh24));
        wr(4'd0, enc(es, mbin));
        wr(4'd2, enc(em, mbin));
        wr(4'd4, enc_hr(eh, mbin, mh24));
        wr(4'd6, enc(ew, mbin));
        wr(4'd7, enc(ed, mbin));
        wr(4'd8, enc(emo, mbin));
        wr(4'd9, enc(ey, mbin));
        wr(4'd11, cb_val(1'b0, mbin, mh24));
    endtask

    task automatic check_time(input string req);
        logic [7:0] v;
        rd(4'd0, v); chk({req, " sec"}, v, enc(es, mbin));
        rd(4'd2, v); chk({req, " min"}, v, enc(em, mbin));
        rd(4'd4, v); chk({req, " hour"}, v, enc_hr(eh, mbin, mh24));
        rd(4'd6, v); chk({req, " dow"}, v, enc(ew, mbin));
        rd(4'd7, v); chk({req, " dom"}, v, enc(ed, mbin));
        rd(4'd8, v); chk({req, " month"}, v, enc(emo, mbin));
        rd(4'd9, v); chk({req, " year"}, v, enc(ey, mbin));
    endtask

    // One tick with a full window; extra > 0 injects a second tick mid-window
    task automatic do_tick(input string req, input int extra);
        logic [7:0] a, s0, sv;
        int n;
        rd(4'd0, s0);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        rd(4'd10, a);
        chk("R3 uip raised", int'(a[7]), 1);
        rd(4'd0, sv);
        chk("R5 old time in window", sv, s0);
        n = 0;
        while (a[7] && n < 64) begin
            n++;
            sec_tick = (n == extra);
            @(negedge clk);
            sec_tick = 1'b0;
            rd(4'd10, a);
        end
        chk("R3 window length", n, WIN);
        if (extra > 0) begin
            repeat (3) @(negedge clk);
            rd(4'd10, a);
            chk("R4 no second window", int'(a[7]), 0);
        end
        model_step();
        check_time(req);
    endtask

    initial begin
        logic [7:0] v;
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        set_model(0, 0, 0, 1, 1, 1, 0, 1'b0, 1'b1);
        check_time("R1 reset");
        rd(4'd10, v); chk("R1 reg A", v, 8'h00);
        rd(4'd11, v); chk("R1 reg B", v, 8'h02);

        // R13 fixed registers
        rd(4'd12, v); chk("R13 reg C", v, 8'h00);
        rd(4'd13, v); chk("R13 reg D", v, 8'h80);
        wr(4'd13, 8'h00);
        rd(4'd13, v); chk("R13 reg D write ignored", v, 8'h80);
        wr(4'd10, 8'hFF);
        rd(4'd10, v); chk("R13 reg A uip read-only", v, 8'h7F);
        wr(4'd10, 8'h00);

        // R2 unused indices
        wr(4'd1, 8'hAA);  rd(4'd1, v);  chk("R2 idx1", v, 8'h00);
        wr(4'd3, 8'h55);  rd(4'd3, v);  chk("R2 idx3", v, 8'h00);
        wr(4'd5, 8'hA5);  rd(4'd5, v);  chk("R2 idx5", v, 8'h00);
        wr(4'd14, 8'h3C); rd(4'd14, v); chk("R2 idx14", v, 8'h00);
        wr(4'd15, 8'hC3); rd(4'd15, v); chk("R2 idx15", v, 8'h00);
        check_time("R2 time untouched");

        // R2 / R7 load and BCD digit carry
        set_model(9, 0, 0, 1, 1, 1, 0, 1'b0, 1'b1);
        load_time();
        check_time("R2 readback");
        do_tick("R7 bcd 09->10", -1);

        // R9 R11 R12 New Year of year 99
        set_model(59, 59, 23, 7, 31, 12, 99, 1'b0, 1'b1);
        load_time();
        do_tick("R9 R11 R12 new year", -1);

        // R11 February
        set_model(59, 59, 23, 3, 28, 2, 24, 1'b0, 1'b1);
        load_time();
        do_tick("R11 feb28 leap", -1);
        set_model(59, 59, 23, 3, 28, 2, 23, 1'b0, 1'b1);
        load_time();
        do_tick("R11 feb28 common", -1);
        set_model(59, 59, 23, 3, 29, 2, 24, 1'b1, 1'b1);
        load_time();
        do_tick("R11 feb29 leap binary", -1);

        // R10 12-hour crossings
        set_model(59, 59, 11, 2, 10, 5, 30, 1'b0, 1'b0);
        load_time();
        do_tick("R10 11am->12pm", -1);
        set_model(59, 59, 12, 2, 10, 5, 30, 1'b0, 1'b0);
        load_time();
        do_tick("R10 12pm->1pm", -1);
        set_model(59, 59, 23, 2, 30, 6, 30, 1'b1, 1'b0);
        load_time();
        do_tick("R10 11pm->12am", -1);

        // R8 binary seconds wrap
        set_model(59, 14, 5, 4, 15, 8, 45, 1'b1, 1'b1);
        load_time();
        do_tick("R8 binary 59 wrap", -1);

        // R4 tick inside window
        set_model(30, 0, 0, 1, 1, 1, 0, 1'b0, 1'b1);
        load_time();
        do_tick("R4 retrigger ignored", 3);

        // R6 freeze: tick ignored
        set_model(20, 10, 10, 2, 2, 2, 2, 1'b0, 1'b1);
        load_time();
        wr(4'd11, cb_val(1'b1, 1'b0, 1'b1));
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        rd(4'd10, v); chk("R6 no window while frozen", int'(v[7]), 0);
        repeat (WIN + 2) @(negedge clk);
        check_time("R6 frozen time");
        wr(4'd11, cb_val(1'b0, 1'b0, 1'b1));

        // R6 freeze during open window aborts it
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        rd(4'd10, v); chk("R6 window opened", int'(v[7]), 1);
        wr(4'd11, cb_val(1'b1, 1'b0, 1'b1));
        @(negedge clk);
        rd(4'd10, v); chk("R6 window aborted", int'(v[7]), 0);
        repeat (WIN + 2) @(negedge clk);
        check_time("R6 abort no update");
        wr(4'd11, cb_val(1'b0, 1'b0, 1'b1));
        repeat (WIN + 2) @(negedge clk);
        check_time("R5 idle stable");

        // Random starting points, biased to carries
        for (int i = 0; i < 40; i++) begin
            bit b, h;
            int mo, y, d;
            b  = 1'($urandom % 2);
            h  = 1'($urandom % 2);
            mo = 1 + int'($urandom % 12);
            y  = int'($urandom % 100);
            d  = ($urandom % 2 == 0) ? dim(mo, y) : 1 + int'($urandom % dim(mo, y));
            set_model(50 + int'($urandom % 10),
                      ($urandom % 2 == 0) ? 59 : int'($urandom % 60),
                      ($urandom % 3 == 0) ? 23 : int'($urandom % 24),
                      1 + int'($urandom % 7), d, mo, y, b, h);
            load_time();
            do_tick(h ? (b ? "R8 R9 random" : "R7 R9 random")
                      : (b ? "R8 R10 random" : "R7 R10 random"), -1);
        end

        summary();
        $finish;
    end

endmodule